// File: doc/BRIEF.md
# Request-Driven Differential Clock Output Gater

This block drives a bank of differential clock output pairs and lets a set of active-low request pins turn selected pairs off and on. A request pin may change at any moment relative to the reference clock. Each pin passes through a two-flop synchronizer and a debounce stage before the gater acts on it. A per-request selection register names the pairs that this request may stop. Pairs that no released request selects keep toggling.

A stop never cuts a half-period short. A selected pair keeps toggling until its next transition lands on the parked level, and freezes there. A drive-mode register sets the parked state. In mode 0 the true leg stays high, the complement leg stays low, and both stay driven. In mode 1 both legs go low and the pair's output enable drops so the pad can float. When the request is asserted again, a shared restart countdown runs. Every pair waiting to restart resumes on the same reference edge. Each output toggles once per reference cycle, so one output period equals two reference cycles.

Top module: `ckgate_ctrl`

## Requirements
- R1: While reset is held, and after it, every selection register and the mode register read zero. During reset every pair drives true=0, complement=1 and enable=1, and after reset every pair toggles.
- R2: A request level is accepted only when the synchronized input has shown that level at two consecutive reference edges. A level that lasts one reference period on the pin has no effect on any output.
- R3: A pair that no released request selects toggles on every reference cycle, with complement equal to the inverse of true and enable high.
- R4: A pair that is stopping keeps toggling until its next transition reaches the parked level. It never produces a level shorter than one reference cycle.
- R5: In drive mode 0 a stopped pair holds true=1, complement=0 and enable=1.
- R6: In drive mode 1 a stopped pair holds true=0, complement=0 and enable=0. Each pair captures the mode when it stops, and a later mode write does not change a parked pair.
- R7: After a request pin goes low again, its stopped pairs resume between 4 and 12 reference cycles later, which is 2 to 6 output periods. All of them make their first transition on the same edge.
- R8: A selection register write made while its request is released has no effect until that request next changes level.
- R9: Writing address r, where r is below the number of requests, loads the selection register of request r, and data bit o selects pair o. Address equal to the number of requests loads the drive mode from data bit 0. Other addresses are ignored.
- R10: A pair is stopped while at least one released request selects it. It resumes only once none does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low reset |
| req_ni | input | NUM_REQ | Asynchronous active-low clock requests |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register address |
| wr_data_i | input | NUM_OUT | Register write data |
| clk_t_o | output | NUM_OUT | True leg of each pair |
| clk_c_o | output | NUM_OUT | Complement leg of each pair |
| clk_oe_o | output | NUM_OUT | Output enable of each pair |

## Verification
The gater can accept a restart for one request and a stop for another on the same reference edge. When the two requests select different pairs, one group parks while the other group's restart countdown runs. The bench provokes this by moving both request pins at the same falling edge. It then checks that the newly selected pairs settle at the parked level captured from the mode register, and that the previously parked pairs toggle freely with their enables restored. Overlapping selections are judged separately: a pair selected by two requests must stay parked until both are asserted.

// File: rtl/ckgate_pkg.sv
package ckgate_pkg;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic acc;
    } dbn_st_t;

    typedef struct packed {
        logic ph;
        logic stopped;
        logic pmode;
    } lane_st_t;

endpackage

// File: rtl/ckgate_sync.sv
module ckgate_sync
    import ckgate_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_ni,
    output logic lvl_o,
    output logic chg_o
);

    dbn_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = req_ni;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        if (st_q.s2 == st_q.prev) begin
            st_d.acc = st_q.s2;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.acc;
    assign chg_o = st_d.acc != st_q.acc;

    // R2: an accepted change must match the synchronized level seen on two edges
    a_r2_two_edge_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.acc != $past(st_q.acc)) |-> (st_q.acc == $past(st_q.s2) && st_q.acc == $past(st_q.s2, 2)));

endmodule

// File: rtl/ckgate_regs.sv
module ckgate_regs #(
    parameter int NUM_REQ = 2,
    parameter int NUM_OUT = 8,
    parameter int AW      = 2
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              wr_en_i,
    input  logic [AW-1:0]                     wr_addr_i,
    input  logic [NUM_OUT-1:0]                wr_data_i,
    output logic [NUM_REQ-1:0][NUM_OUT-1:0]   mask_o,
    output logic                              mode_o
);

    typedef struct packed {
        logic [NUM_REQ-1:0][NUM_OUT-1:0] mask;
        logic                            mode;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            for (int r = 0; r < NUM_REQ; r++) begin
                if (int'(wr_addr_i) == r) begin
                    st_d.mask[r] = wr_data_i;
                end
            end
            if (int'(wr_addr_i) == NUM_REQ) begin
                st_d.mode = wr_data_i[0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign mode_o = st_q.mode;

    // R9: a write outside the map leaves every register unchanged
    a_r9_ignore_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && int'(wr_addr_i) > NUM_REQ) |=> (mask_o == $past(mask_o) && mode_o == $past(mode_o)));

endmodule

// File: rtl/ckgate_lane.sv
module ckgate_lane
    import ckgate_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_i,
    input  logic resume_i,
    input  logic mode_i,
    output logic t_o,
    output logic c_o,
    output logic oe_o,
    output logic stopped_o
);

    lane_st_t st_d, st_q;
    logic     park_lvl;

    always_comb begin
        st_d     = st_q;
        park_lvl = ~mode_i;
        if (st_q.stopped) begin
            if (resume_i && !stop_i) begin
                st_d.stopped = 1'b0;
                st_d.ph      = ~st_q.ph;
            end
        end else begin
            st_d.ph = ~st_q.ph;
            if (stop_i && (~st_q.ph == park_lvl)) begin
                st_d.stopped = 1'b1;
                st_d.pmode   = mode_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign t_o       = st_q.ph;
    assign c_o       = st_q.stopped ? 1'b0 : ~st_q.ph;
    assign oe_o      = ~(st_q.stopped & st_q.pmode);
    assign stopped_o = st_q.stopped;

    // R4: a running lane changes level on every cycle, so no short level appears
    a_r4_full_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !st_q.stopped && !$past(st_q.stopped)) |-> (st_q.ph != $past(st_q.ph)));

    // R4: entering the stopped state happens on the parked level of the captured mode
    a_r4_park_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.stopped) |-> (st_q.ph == ~st_q.pmode));

    // R5: mode 0 park drives true high, complement low
    a_r5_park_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.stopped && !st_q.pmode) |-> (t_o && !c_o && oe_o));

    // R6: an undriven pair has both legs low
    a_r6_undriven_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_o |-> (!t_o && !c_o));

    // R7: a lane leaves the stopped state only on a resume with no stop request
    a_r7_resume_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.stopped) |-> $past(resume_i && !stop_i));

endmodule

// File: rtl/ckgate_ctrl.sv
module ckgate_ctrl #(
    parameter int NUM_REQ     = 2,
    parameter int NUM_OUT     = 8,
    parameter int RESTART_LAT = 2,
    localparam int AW         = $clog2(NUM_REQ + 1),
    localparam int CW         = $clog2(RESTART_LAT + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_REQ-1:0] req_ni,
    input  logic               wr_en_i,
    input  logic [AW-1:0]      wr_addr_i,
    input  logic [NUM_OUT-1:0] wr_data_i,
    output logic [NUM_OUT-1:0] clk_t_o,
    output logic [NUM_OUT-1:0] clk_c_o,
    output logic [NUM_OUT-1:0] clk_oe_o
);

    typedef struct packed {
        logic [NUM_REQ-1:0][NUM_OUT-1:0] eff;
        logic [CW-1:0]                   cnt;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [NUM_REQ-1:0]              lvl;
    logic [NUM_REQ-1:0]              chg;
    logic [NUM_REQ-1:0][NUM_OUT-1:0] mask;
    logic                            mode;
    logic [NUM_OUT-1:0]              stop_want;
    logic [NUM_OUT-1:0]              stopped_vec;
    logic                            pending;
    logic                            resume;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        ckgate_sync u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .req_ni (req_ni[r]),
            .lvl_o  (lvl[r]),
            .chg_o  (chg[r])
        );
    end

    ckgate_regs #(
        .NUM_REQ (NUM_REQ),
        .NUM_OUT (NUM_OUT),
        .AW      (AW)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .mask_o    (mask),
        .mode_o    (mode)
    );

    always_comb begin
        stop_want = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (lvl[r]) begin
                stop_want = stop_want | st_q.eff[r];
            end
        end
        pending = |(stopped_vec & ~stop_want);
        resume  = pending && (st_q.cnt == CW'(RESTART_LAT - 1));
    end

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (chg[r]) begin
                st_d.eff[r] = mask[r];
            end
        end
        if (!pending || resume) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        ckgate_lane u_lane (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .stop_i    (stop_want[o]),
            .resume_i  (resume),
            .mode_i    (mode),
            .t_o       (clk_t_o[o]),
            .c_o       (clk_c_o[o]),
            .oe_o      (clk_oe_o[o]),
            .stopped_o (stopped_vec[o])
        );
    end

    // R3: a lane may only become stopped when a released request selected it
    a_r3_stop_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((stopped_vec & ~$past(stopped_vec) & ~$past(stop_want)) == '0));

    // R7: when any lane resumes, no released lane is left behind
    a_r7_same_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && (($past(stopped_vec) & ~stopped_vec) != '0))
            |-> ((stopped_vec & ~$past(stop_want)) == '0));

    // R8: the captured selection only moves when a request level changes
    a_r8_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(chg) == '0) |-> (st_q.eff == $past(st_q.eff)));

endmodule

// File: tb/ckgate_ctrl_tb.sv
module ckgate_ctrl_tb;

    localparam int N  = 8;
    localparam int NR = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] req_n = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [N-1:0]  wr_data = '0;
    logic [N-1:0]  t_o, c_o, oe_o;

    int nchk = 0;
    int nbad = 0;
    int cyc_cnt = 0;

    typedef struct {
        string        tag;
        int           cyc;
        logic [N-1:0] run;
        logic [N-1:0] park;
        logic [N-1:0] pt;
        logic [N-1:0] pc;
        logic [N-1:0] poe;
    } item_t;

    item_t q[$];

    always #2 clk = ~clk;

    ckgate_ctrl #(.NUM_REQ(NR), .NUM_OUT(N), .RESTART_LAT(2)) u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .req_ni    (req_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .clk_t_o   (t_o),
        .clk_c_o   (c_o),
        .clk_oe_o  (oe_o)
    );

    // monitor: samples at falling edges, pops expected items
    initial begin
        logic [N-1:0] pt_s, ct_s, ot_s, pv_t;
        item_t it;
        pt_s = '0; ct_s = '0; ot_s = '0;
        forever begin
            @(negedge clk);
            cyc_cnt++;
            pv_t = pt_s;
            pt_s = t_o; ct_s = c_o; ot_s = oe_o;
            while (q.size() > 0 && q[0].cyc <= cyc_cnt) begin
                logic bad;
                it = q.pop_front();
                bad = 1'b0;
                if (((pt_s ^ pv_t) & it.run) != it.run) bad = 1'b1;
                if (((ct_s ^ ~pt_s) & it.run) != '0) bad = 1'b1;
                if ((ot_s & it.run) != it.run) bad = 1'b1;
                if (((pt_s ^ it.pt) & it.park) != '0) bad = 1'b1;
                if (((ct_s ^ it.pc) & it.park) != '0) bad = 1'b1;
                if (((ot_s ^ it.poe) & it.park) != '0) bad = 1'b1;
                if (((pt_s ^ pv_t) & it.park) != '0) bad = 1'b1;
                nchk++;
                if (bad) begin
                    nbad++;
                    $display("FAIL %s: t=%h prev_t=%h c=%h oe=%h exp run=%h park=%h pt=%h pc=%h poe=%h",
                             it.tag, pt_s, pv_t, ct_s, ot_s, it.run, it.park, it.pt, it.pc, it.poe);
                end
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input string tag, input logic [N-1:0] run, input logic [N-1:0] park,
                        input logic [N-1:0] pt, input logic [N-1:0] pc, input logic [N-1:0] poe);
        item_t it;
        it.tag = tag; it.cyc = cyc_cnt + 2;
        it.run = run; it.park = park; it.pt = pt; it.pc = pc; it.poe = poe;
        q.push_back(it);
        wait_n(4);
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R7: restart latency and simultaneity for outputs 3..0 parked high
    task automatic lat_check();
        int first [4];
        logic ok;
        for (int b = 0; b < 4; b++) first[b] = 0;
        req_n[0] = 1'b0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            for (int b = 0; b < 4; b++) begin
                if (first[b] == 0 && t_o[b] == 1'b0) first[b] = k;
            end
        end
        ok = (first[0] >= 4) && (first[0] <= 12);
        for (int b = 1; b < 4; b++) if (first[b] != first[0]) ok = 1'b0;
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL R7 restart: first=%0d,%0d,%0d,%0d exp equal within 4..12",
                     first[0], first[1], first[2], first[3]);
        end
    endtask

    initial begin
        wait_n(2);
        push("R1 reset state", '0, 8'hFF, 8'h00, 8'hFF, 8'hFF);
        rst_n = 1'b1;
        wait_n(3);
        push("R1 free run after reset", 8'hFF, '0, '0, '0, '0);

        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h3C);
        wr(2'd2, 8'h00);
        req_n[0] = 1'b1;
        wait_n(10);
        push("R5 R3 R4 mode0 park", 8'hF0, 8'h0F, 8'h0F, 8'h00, 8'hFF);

        lat_check();
        wait_n(4);
        push("R7 all running after restart", 8'hFF, '0, '0, '0, '0);

        req_n[0] = 1'b1;
        @(negedge clk);
        req_n[0] = 1'b0;
        wait_n(10);
        push("R2 one-cycle glitch ignored", 8'hFF, '0, '0, '0, '0);

        req_n[0] = 1'b1;
        wait_n(10);
        wr(2'd0, 8'hFF);
        wait_n(5);
        push("R8 write while stopped ignored", 8'hF0, 8'h0F, 8'h0F, 8'h00, 8'hFF);
        req_n[0] = 1'b0;
        wait_n(14);
        push("R8 resume", 8'hFF, '0, '0, '0, '0);
        req_n[0] = 1'b1;
        wait_n(10);
        push("R8 R9 new selection applied", '0, 8'hFF, 8'hFF, 8'h00, 8'hFF);
        req_n[0] = 1'b0;
        wait_n(14);
        push("R9 resume all", 8'hFF, '0, '0, '0, '0);

        wr(2'd2, 8'h01);
        req_n[1] = 1'b1;
        wait_n(10);
        push("R6 mode1 undriven park", 8'hC3, 8'h3C, 8'h00, 8'h00, 8'h00);

        wr(2'd3, 8'hFF);
        wait_n(3);
        push("R9 unmapped write ignored", 8'hC3, 8'h3C, 8'h00, 8'h00, 8'h00);

        wr(2'd0, 8'h03);
        req_n[1] = 1'b0;
        req_n[0] = 1'b1;
        wait_n(14);
        push("R7 R6 coincident stop and restart", 8'hFC, 8'h03, 8'h00, 8'h00, 8'h00);
        req_n[0] = 1'b0;
        wait_n(14);
        push("R7 all running", 8'hFF, '0, '0, '0, '0);

        wr(2'd0, 8'h0F);
        wr(2'd2, 8'h00);
        req_n = 2'b11;
        wait_n(10);
        push("R10 union stopped", 8'hC0, 8'h3F, 8'h3F, 8'h00, 8'hFF);
        wr(2'd2, 8'h01);
        wait_n(3);
        push("R6 captured mode kept", 8'hC0, 8'h3F, 8'h3F, 8'h00, 8'hFF);
        req_n[0] = 1'b0;
        wait_n(14);
        push("R10 overlap stays parked", 8'hC3, 8'h3C, 8'h3C, 8'h00, 8'hFF);
        req_n[1] = 1'b0;
        wait_n(14);
        push("R10 all released", 8'hFF, '0, '0, '0, '0);

        wait_n(4);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog: run did not end, exp end before 20000 cycles");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule